// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block sits beside an 8-bit CPU datapath. When reset is released, or when an interrupt is accepted at an instruction boundary, it takes over the memory bus and stalls the core. It then performs the whole entry sequence and hands the bus back. For a reset, it fetches the start address and loads the architectural registers with their defined start values. For an interrupt, it saves the return address and status on the stack, masks further maskable requests, fetches the handler address from the matching vector and loads it into the program counter.

The core supplies its current program counter, status byte and stack pointer, and a byte read port that returns data in the same cycle. The sequencer returns load strobes with new values for the program counter, status byte and stack pointer, plus a strobe that clears the core's extra index and base-page registers. The status byte is laid out from bit 7 down to bit 0 as: negative, overflow, extended-stack, break, decimal, interrupt-mask, zero, carry. A non-maskable request is accepted only on a fresh assertion of its line. A maskable request is accepted while its line is high and the mask bit is clear. Opcode decoding and the return from an interrupt belong to the core.

Top module: `isq_top`

## Requirements
- R1: While reset is applied, and from its release until the start address is loaded, `busy` is high. After release the block reads 0xFFFC, then 0xFFFD, and loads `pc_out` = {byte at 0xFFFD, byte at 0xFFFC}.
- R2: At the end of the reset sequence the block loads the stack pointer with 0x01FF and the status byte with 0x36 (bits 5, 4, 2 and 1 set). It also pulses `index_clr` exactly once.
- R3: Interrupt entry makes three writes, in this order: PC high byte, PC low byte, then status with bit 4 forced to 0. Each write goes to 0x0100 plus the current stack-pointer low byte, and that low byte then decrements, wrapping from 0x00 to 0xFF.
- R4: In the cycle of the status push, and before any vector read, the block loads the status byte with bit 3 cleared and bit 2 set. In the same cycle it loads the stack pointer with its low byte reduced by 3, keeping the high byte.
- R5: A maskable entry reads 0xFFFE then 0xFFFF. A non-maskable entry reads 0xFFFA then 0xFFFB. The new PC is {high byte, low byte}.
- R6: An accepted entry keeps `busy` high for exactly 7 cycles, starting in the cycle after the boundary strobe. `pc_load` pulses in the last of those cycles.
- R7: A non-maskable request is accepted only after a 0-to-1 transition of `nmi_req`. The transition is remembered until the next boundary, and a line held high is not accepted again.
- R8: A maskable request is accepted at a boundary only while `irq_req` is high and `cpu_status` bit 2 is 0. A request refused because of the mask leaves no trace, and a later boundary with the mask clear accepts it.
- R9: If a fresh non-maskable transition and a maskable request meet at the same boundary, the non-maskable one is taken.
- R10: While `busy` is low there are no bus reads or writes. Boundary strobes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, accepted on rising transition |
| insn_boundary | input | 1 | Core is between instructions this cycle |
| cpu_pc | input | 16 | Current program counter |
| cpu_status | input | 8 | Current status byte |
| cpu_sp | input | 16 | Current stack pointer |
| rd_data | input | 8 | Read data for `mem_addr`, same cycle |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Bus read |
| mem_wr | output | 1 | Bus write |
| wr_data | output | 8 | Write data |
| busy | output | 1 | Core must stall |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 16 | New program counter |
| status_load | output | 1 | Load `status_out` into the status byte |
| status_out | output | 8 | New status byte |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | 16 | New stack pointer |
| index_clr | output | 1 | Clear the extra index and base-page registers |

## Verification
The hardest case to reach from the ports is a non-maskable line that is already high when a boundary arrives. It must not be taken again, yet a new transition must be. The bench therefore takes one non-maskable entry, raises another boundary with the line still high, then drops and raises the line again. Priority is reached by raising the non-maskable line in the same cycle as a boundary strobe while an unmasked maskable request is held high. The stack wrap is reached by presetting the stack pointer low byte to 0x01 before an entry.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ACK    = 3'd1,
    S_PUSH_H = 3'd2,
    S_PUSH_L = 3'd3,
    S_PUSH_S = 3'd4,
    S_VEC_L  = 3'd5,
    S_VEC_H  = 3'd6,
    S_FIN    = 3'd7
  } seq_state_t;

  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_NMI   = 2'd1,
    K_IRQ   = 2'd2
  } entry_kind_t;

  // status bit positions
  localparam int FLG_E = 5;
  localparam int FLG_B = 4;
  localparam int FLG_D = 3;
  localparam int FLG_I = 2;
  localparam int FLG_Z = 1;
endpackage

// File: rtl/isq_rst_sync.sv
module isq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/isq_arbiter.sv
module isq_arbiter
  import isq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        irq_req,
  input  logic        irq_masked,
  input  logic        boundary,
  input  logic        idle,
  output logic        take,
  output entry_kind_t take_kind
);
  logic nmi_prev_q, nmi_prev_d;
  logic nmi_pend_q, nmi_pend_d;
  logic nmi_rise, nmi_ready, can_take, take_nmi, take_irq;

  always_comb begin
    nmi_rise   = nmi_req & ~nmi_prev_q;
    nmi_ready  = nmi_pend_q | nmi_rise;
    can_take   = idle & boundary;
    take_nmi   = can_take & nmi_ready;
    take_irq   = can_take & ~nmi_ready & irq_req & ~irq_masked;
    take       = take_nmi | take_irq;
    take_kind  = take_nmi ? K_NMI : K_IRQ;
    nmi_prev_d = nmi_req;
    nmi_pend_d = nmi_ready & ~take_nmi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_prev_d;
      nmi_pend_q <= nmi_pend_d;
    end
  end
endmodule

// File: rtl/isq_sequencer.sv
module isq_sequencer
  import isq_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  entry_kind_t       take_kind,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [DATA_W-1:0] cpu_status,
  input  logic [ADDR_W-1:0] cpu_sp,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_out,
  output logic              status_load,
  output logic [DATA_W-1:0] status_out,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_out,
  output logic              index_clr
);
  localparam int                PAGE_W       = ADDR_W - DATA_W;
  localparam logic [PAGE_W-1:0] STACK_PAGE   = PAGE_W'(1);
  localparam logic [DATA_W-1:0] MASK_B       = DATA_W'(1) << FLG_B;
  localparam logic [DATA_W-1:0] MASK_D       = DATA_W'(1) << FLG_D;
  localparam logic [DATA_W-1:0] MASK_I       = DATA_W'(1) << FLG_I;
  localparam logic [DATA_W-1:0] RESET_STATUS = (DATA_W'(1) << FLG_E) | MASK_B | MASK_I
                                               | (DATA_W'(1) << FLG_Z);
  localparam logic [ADDR_W-1:0] RESET_SP     = {STACK_PAGE, {DATA_W{1'b1}}};

  seq_state_t        state_q, state_d;
  entry_kind_t       kind_q;
  logic [ADDR_W-1:0] pc_q, sp_q, vec_base;
  logic [DATA_W-1:0] stat_q, vlo_q, vhi_q, sp_lo;
  logic [PAGE_W-1:0] sp_hi;
  logic              cap_en, dec_en, vlo_en, vhi_en;

  assign sp_lo = sp_q[DATA_W-1:0];
  assign sp_hi = sp_q[ADDR_W-1:DATA_W];

  // next state
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      S_IDLE:   if (take) begin state_d = S_ACK; cap_en = 1'b1; end
      S_ACK:    state_d = S_PUSH_H;
      S_PUSH_H: state_d = S_PUSH_L;
      S_PUSH_L: state_d = S_PUSH_S;
      S_PUSH_S: state_d = S_VEC_L;
      S_VEC_L:  state_d = S_VEC_H;
      S_VEC_H:  state_d = S_FIN;
      S_FIN:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (kind_q)
      K_NMI:   vec_base = VEC_NMI;
      K_IRQ:   vec_base = VEC_IRQ;
      default: vec_base = VEC_RST;
    endcase
  end

  // bus and load outputs
  always_comb begin
    mem_addr    = '0;
    mem_rd      = 1'b0;
    mem_wr      = 1'b0;
    wr_data     = '0;
    pc_load     = 1'b0;
    pc_out      = {vhi_q, vlo_q};
    status_load = 1'b0;
    status_out  = '0;
    sp_load     = 1'b0;
    sp_out      = '0;
    index_clr   = 1'b0;
    vlo_en      = 1'b0;
    vhi_en      = 1'b0;
    unique case (state_q)
      S_PUSH_H: begin
        mem_wr   = 1'b1;
        mem_addr = {STACK_PAGE, sp_lo};
        wr_data  = DATA_W'(pc_q >> DATA_W);
      end
      S_PUSH_L: begin
        mem_wr   = 1'b1;
        mem_addr = {STACK_PAGE, sp_lo};
        wr_data  = pc_q[DATA_W-1:0];
      end
      S_PUSH_S: begin
        mem_wr      = 1'b1;
        mem_addr    = {STACK_PAGE, sp_lo};
        wr_data     = stat_q & ~MASK_B;
        status_load = 1'b1;
        status_out  = (stat_q & ~MASK_D) | MASK_I;
        sp_load     = 1'b1;
        sp_out      = {sp_hi, sp_lo - DATA_W'(1)};
      end
      S_VEC_L: begin
        mem_rd   = 1'b1;
        mem_addr = vec_base;
        vlo_en   = 1'b1;
      end
      S_VEC_H: begin
        mem_rd   = 1'b1;
        mem_addr = vec_base + ADDR_W'(1);
        vhi_en   = 1'b1;
      end
      S_FIN: begin
        pc_load = 1'b1;
        if (kind_q == K_RESET) begin
          status_load = 1'b1;
          status_out  = RESET_STATUS;
          sp_load     = 1'b1;
          sp_out      = RESET_SP;
          index_clr   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign dec_en = mem_wr;
  assign busy   = (state_q != S_IDLE);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_VEC_L;
      kind_q  <= K_RESET;
      pc_q    <= '0;
      stat_q  <= '0;
      sp_q    <= '0;
      vlo_q   <= '0;
      vhi_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        kind_q <= take_kind;
        pc_q   <= cpu_pc;
        stat_q <= cpu_status;
        sp_q   <= cpu_sp;
      end else if (dec_en) begin
        sp_q[DATA_W-1:0] <= sp_lo - DATA_W'(1);
      end
      if (vlo_en) vlo_q <= rd_data;
      if (vhi_en) vhi_q <= rd_data;
    end
  end
endmodule

// File: rtl/isq_top.sv
module isq_top
  import isq_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 8,
  parameter int                SYNC_N  = 2,
  parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              nmi_req,
  input  logic              insn_boundary,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [DATA_W-1:0] cpu_status,
  input  logic [ADDR_W-1:0] cpu_sp,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_out,
  output logic              status_load,
  output logic [DATA_W-1:0] status_out,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_out,
  output logic              index_clr
);
  logic        rst_n_int;
  logic        take;
  entry_kind_t take_kind;

  isq_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  isq_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .nmi_req    (nmi_req),
    .irq_req    (irq_req),
    .irq_masked (cpu_status[FLG_I]),
    .boundary   (insn_boundary),
    .idle       (~busy),
    .take       (take),
    .take_kind  (take_kind)
  );

  isq_sequencer #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .VEC_NMI (VEC_NMI),
    .VEC_RST (VEC_RST),
    .VEC_IRQ (VEC_IRQ)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .take        (take),
    .take_kind   (take_kind),
    .cpu_pc      (cpu_pc),
    .cpu_status  (cpu_status),
    .cpu_sp      (cpu_sp),
    .rd_data     (rd_data),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .wr_data     (wr_data),
    .busy        (busy),
    .pc_load     (pc_load),
    .pc_out      (pc_out),
    .status_load (status_load),
    .status_out  (status_out),
    .sp_load     (sp_load),
    .sp_out      (sp_out),
    .index_clr   (index_clr)
  );
endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              pc_load,
  input logic              status_load,
  input logic [DATA_W-1:0] status_out,
  input logic              sp_load,
  input logic [ADDR_W-1:0] sp_out
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  // R3: every push lands in the stack page
  a_r3_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr[ADDR_W-1:DATA_W] == PAGE_W'(1));

  // R3: the status push carries bit 4 cleared
  a_r3_status_push_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && status_load) |-> !wr_data[4]);

  // R4: status loaded with the mask set and decimal cleared during the status push
  a_r4_entry_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && status_load) |-> (status_out[2] && !status_out[3]));

  // R4: stack pointer loaded one below the last push address
  a_r4_sp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && status_load) |->
      (sp_load && sp_out[DATA_W-1:0] == mem_addr[DATA_W-1:0] - DATA_W'(1)));

  // R1 / R5: a vector high-byte read directly follows its low-byte read
  a_r5_vec_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr[0]) |->
      ($past(mem_rd) && $past(mem_addr) == mem_addr - ADDR_W'(1)));

  // R6: the stall ends right after the program counter load
  a_r6_pc_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  // R10: no bus traffic while the core owns the bus
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  // R10: read and write never together
  a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));
endmodule

bind isq_top isq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_addr    (mem_addr),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .wr_data     (wr_data),
  .busy        (busy),
  .pc_load     (pc_load),
  .status_load (status_load),
  .status_out  (status_out),
  .sp_load     (sp_load),
  .sp_out      (sp_out)
);

// File: tb/sim_isq_top.sv
module sim_isq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, irq_req, nmi_req, insn_boundary;
  logic [15:0] cpu_pc, cpu_sp, mem_addr, pc_out, sp_out;
  logic [7:0]  cpu_status, rd_data, wr_data, status_out;
  logic        mem_rd, mem_wr, busy, pc_load, status_load, sp_load, index_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  isq_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .insn_boundary(insn_boundary), .cpu_pc(cpu_pc), .cpu_status(cpu_status),
    .cpu_sp(cpu_sp), .rd_data(rd_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .wr_data(wr_data), .busy(busy), .pc_load(pc_load),
    .pc_out(pc_out), .status_load(status_load), .status_out(status_out),
    .sp_load(sp_load), .sp_out(sp_out), .index_clr(index_clr)
  );

  // vector contents
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'hBC;
      16'hFFFB: return 8'h9A;
      16'hFFFC: return 8'h23;
      16'hFFFD: return 8'hC1;
      16'hFFFE: return 8'h78;
      16'hFFFF: return 8'h56;
      default:  return 8'h00;
    endcase
  endfunction
  assign rd_data = mem_byte(mem_addr);

  // core register model
  logic [15:0] pc_m, sp_m;
  logic [7:0]  st_m;
  assign cpu_pc = pc_m;
  assign cpu_sp = sp_m;
  assign cpu_status = st_m;

  int checks = 0, failures = 0;
  int wr_cnt, rd_cnt, busy_cnt, idx_cnt;
  logic [15:0] wr_addr [8];
  logic [7:0]  wr_dat  [8];
  logic [15:0] rd_addr [8];

  always @(negedge clk) begin
    if (pc_load) pc_m = pc_out;
    if (sp_load) sp_m = sp_out;
    if (status_load) st_m = status_out;
    if (busy) busy_cnt++;
    if (index_clr) idx_cnt++;
    if (mem_wr && wr_cnt < 8) begin
      wr_addr[wr_cnt] = mem_addr;
      wr_dat[wr_cnt] = wr_data;
      wr_cnt++;
    end
    if (mem_rd && rd_cnt < 8 && (rd_cnt == 0 || rd_addr[rd_cnt-1] != mem_addr)) begin
      rd_addr[rd_cnt] = mem_addr;
      rd_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_cnt = 0; rd_cnt = 0; busy_cnt = 0; idx_cnt = 0;
  endtask

  task automatic pulse_boundary();
    @(negedge clk);
    insn_boundary = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_req = 1'b0; nmi_req = 1'b0; insn_boundary = 1'b0;
    pc_m = 16'h0000; sp_m = 16'h0000; st_m = 8'h00;
    wait_cycles(3);
    chk("R1", "busy during reset", busy, 1);
    chk("R10", "no write during reset", mem_wr, 0);
    clear_logs();
    rst_n = 1'b1;
    @(negedge clk);
    wait_idle();
    chk("R1", "reset read count", rd_cnt, 2);
    chk("R1", "first reset read", rd_addr[0], 16'hFFFC);
    chk("R1", "second reset read", rd_addr[1], 16'hFFFD);
    chk("R1", "reset pc", pc_m, 16'hC123);
    chk("R2", "reset sp", sp_m, 16'h01FF);
    chk("R2", "reset status", st_m, 8'h36);
    chk("R2", "index clear pulses", idx_cnt, 1);
    chk("R10", "no writes in reset sequence", wr_cnt, 0);
  endtask

  task automatic t_irq_entry();
    pc_m = 16'h1234; sp_m = 16'h01F0; st_m = 8'hDB;
    irq_req = 1'b1;
    clear_logs();
    pulse_boundary();
    wait_idle();
    irq_req = 1'b0;
    chk("R6", "irq busy cycles", busy_cnt, 7);
    chk("R3", "irq write count", wr_cnt, 3);
    chk("R3", "push1 addr", wr_addr[0], 16'h01F0);
    chk("R3", "push1 data pc hi", wr_dat[0], 8'h12);
    chk("R3", "push2 addr", wr_addr[1], 16'h01EF);
    chk("R3", "push2 data pc lo", wr_dat[1], 8'h34);
    chk("R3", "push3 addr", wr_addr[2], 16'h01EE);
    chk("R3", "push3 status b cleared", wr_dat[2], 8'hCB);
    chk("R4", "status after entry", st_m, 8'hD7);
    chk("R4", "sp after entry", sp_m, 16'h01ED);
    chk("R5", "irq vector lo read", rd_addr[0], 16'hFFFE);
    chk("R5", "irq vector hi read", rd_addr[1], 16'hFFFF);
    chk("R5", "irq pc", pc_m, 16'h5678);
  endtask

  task automatic t_irq_masked();
    pc_m = 16'h2000; sp_m = 16'h01FF; st_m = 8'h04;
    irq_req = 1'b1;
    clear_logs();
    pulse_boundary();
    wait_cycles(10);
    chk("R8", "masked irq busy", busy_cnt, 0);
    chk("R8", "masked irq writes", wr_cnt, 0);
    chk("R8", "masked irq pc kept", pc_m, 16'h2000);
    st_m = 8'h00;
    clear_logs();
    pulse_boundary();
    wait_idle();
    irq_req = 1'b0;
    chk("R8", "unmasked later taken busy", busy_cnt, 7);
    chk("R8", "unmasked later pc", pc_m, 16'h5678);
  endtask

  task automatic t_nmi_edge();
    pc_m = 16'h3456; sp_m = 16'h01FF; st_m = 8'h04;
    clear_logs();
    @(negedge clk);
    nmi_req = 1'b1;
    wait_cycles(3);
    chk("R7", "nmi not taken without boundary", busy_cnt, 0);
    pulse_boundary();
    wait_idle();
    chk("R7", "pending nmi taken despite mask", busy_cnt, 7);
    chk("R5", "nmi vector lo read", rd_addr[0], 16'hFFFA);
    chk("R5", "nmi vector hi read", rd_addr[1], 16'hFFFB);
    chk("R5", "nmi pc", pc_m, 16'h9ABC);
    clear_logs();
    pulse_boundary();
    wait_cycles(10);
    chk("R7", "held nmi not retaken", busy_cnt, 0);
    @(negedge clk);
    nmi_req = 1'b0;
    wait_cycles(2);
    nmi_req = 1'b1;
    clear_logs();
    pulse_boundary();
    wait_idle();
    chk("R7", "fresh nmi edge taken", busy_cnt, 7);
    nmi_req = 1'b0;
  endtask

  task automatic t_stack_wrap();
    pc_m = 16'hABCD; sp_m = 16'h0101; st_m = 8'h1C;
    clear_logs();
    @(negedge clk);
    nmi_req = 1'b1;
    insn_boundary = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0;
    wait_idle();
    nmi_req = 1'b0;
    chk("R3", "wrap push1 addr", wr_addr[0], 16'h0101);
    chk("R3", "wrap push2 addr", wr_addr[1], 16'h0100);
    chk("R3", "wrap push3 addr", wr_addr[2], 16'h01FF);
    chk("R3", "wrap pushed status", wr_dat[2], 8'h0C);
    chk("R4", "wrap sp", sp_m, 16'h01FE);
    chk("R4", "decimal cleared", st_m, 8'h14);
  endtask

  task automatic t_priority();
    pc_m = 16'h4000; sp_m = 16'h01FF; st_m = 8'h00;
    irq_req = 1'b1;
    wait_cycles(2);
    clear_logs();
    @(negedge clk);
    nmi_req = 1'b1;
    insn_boundary = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0;
    wait_idle();
    chk("R9", "nmi wins first read", rd_addr[0], 16'hFFFA);
    chk("R9", "nmi wins pc", pc_m, 16'h9ABC);
    irq_req = 1'b0;
    nmi_req = 1'b0;
    wait_cycles(2);
  endtask

  task automatic t_busy_strobe();
    pc_m = 16'h5000; sp_m = 16'h01FF; st_m = 8'h00;
    irq_req = 1'b1;
    clear_logs();
    pulse_boundary();
    insn_boundary = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0;
    wait_idle();
    irq_req = 1'b0;
    wait_cycles(8);
    chk("R10", "strobe during busy ignored", busy_cnt, 7);
    chk("R10", "single entry writes", wr_cnt, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog R6 sequence did not finish actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_irq_entry();
    t_irq_masked();
    t_nmi_edge();
    t_stack_wrap();
    t_priority();
    t_busy_strobe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule